// File: doc/BRIEF.md
# Self-Routing Crossbar Input Port Controller

This block sits at one input row of a packet-pipelined N×N crossbar. Each arriving packet is bit-serial. The leading log2(N) bits name the destination column, most significant bit first, and the L bits after them are the payload. The controller captures the destination, strips it from the packet and passes only the payload through a fixed delay line. It then builds a one-hot column token by a two-phase countdown. That countdown takes the same N clocks for every destination, so the moment the token lands does not depend on where it is going.

Between packets, the surrounding fabric runs a reprogramming phase. A clean pulse opens every crosspoint of the row and returns the controller to address capture. A select pulse then closes the single crosspoint under the placed token. The crosspoint state is kept as an N-bit column register. Until clean arrives, the controller stays busy and refuses a new packet start.

Top module: `xbar_in_ctrl`

## Requirements
- R1: N is a power of two and is at least 4, and LA = log2(N). The first LA accepted bits of a packet form the destination A, MSB first. The placed token has bit A set in token_o.
- R2: token_vld_o is high for exactly one cycle. That cycle follows the (N+1)th rising edge after the edge that samples the last address bit, for every value of A.
- R3: From token_vld_o onward, token_o holds the one-hot token until a select pulse consumes it. At all other times token_o is zero.
- R4: Only the L payload bits are forwarded, in arrival order. Each bit appears on pay_o with pay_vld_o high exactly D−1 edges after the edge that samples it, where D = 2 + L − LA.
- R5: A cycle with bit_vld_i low is skipped by both address capture and payload counting. Gaps anywhere in a packet therefore change neither the address nor the payload.
- R6: An accepted packet start (sop_i with bit_vld_i while idle) sets busy_o. A packet start seen while busy_o is high is dropped, and err_o pulses for one cycle after that edge.
- R7: A clean pulse returns the controller to address capture, so busy_o is low after that edge.
- R8: A clean pulse without select opens every crosspoint, so xpt_o is zero after that edge.
- R9: A select pulse while a token is held sets xpt_o to that token and clears token_o. A select pulse with no token held leaves xpt_o unchanged. At most one bit of xpt_o is ever set.
- R10: While rst_ni is low, busy_o, err_o, pay_vld_o, token_vld_o, token_o and xpt_o are all zero.
- R11: Valid bits that arrive while idle without sop_i are ignored. They start no packet and produce no payload or token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sop_i | input | 1 | Marks the first bit of a packet |
| bit_vld_i | input | 1 | Serial bit valid |
| bit_i | input | 1 | Serial packet bit |
| clean_i | input | 1 | Opens the row's crosspoints and rearms capture |
| select_i | input | 1 | Closes the crosspoint under the held token |
| pay_vld_o | output | 1 | Delayed payload bit valid |
| pay_o | output | 1 | Delayed payload bit |
| token_vld_o | output | 1 | One-cycle token placement strobe |
| token_o | output | N | Held one-hot column token |
| busy_o | output | 1 | Packet accepted, waiting for clean |
| err_o | output | 1 | Packet start refused while busy |
| xpt_o | output | N | Closed-crosspoint column register |

## Verification
The bench sends packets to column 0, to column N−1 and to a middle column, and checks that each token lands at the same fixed latency. If the token were only counted up to A, or only shifted A places, the latency would vary with the address and the bench would catch it at the edge columns. Some packets have a gap inserted inside the address or inside the payload. A design that did not stall on the gap would capture a wrong column or misplace the payload timing. The bench also checks four more cases: a start marker while busy, which must raise an error and add no payload bit; stray valid bits while idle; a select with no held token, which must not clear the crosspoints; and a packet that starts right after clean while the previous payload is still draining.

// File: rtl/xic_pkg.sv
package xic_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE,
    CAP_ADDR,
    CAP_PAY,
    CAP_HOLD
  } cap_state_e;
endpackage

// File: rtl/xic_addr_capture.sv
module xic_addr_capture
  import xic_pkg::*;
#(
  parameter int N_COLS  = 8,
  parameter int PAY_LEN = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sop_i,
  input  logic                          bit_vld_i,
  input  logic                          bit_i,
  input  logic                          clean_i,
  output logic                          addr_vld_o,
  output logic [$clog2(N_COLS)-1:0]     addr_o,
  output logic                          pay_vld_o,
  output logic                          pay_bit_o,
  output logic                          busy_o,
  output logic                          err_o
);
  localparam int LA  = $clog2(N_COLS);
  localparam int ACW = $clog2(LA + 1);
  localparam int PCW = $clog2(PAY_LEN + 1);

  cap_state_e     state_q;
  logic [LA-1:0]  sreg_q;
  logic [ACW-1:0] acnt_q;
  logic [PCW-1:0] pcnt_q;
  logic           take;

  // a start marker is only honoured in idle
  assign take      = bit_vld_i & ~sop_i;
  assign pay_vld_o = (state_q == CAP_PAY) & take;
  assign pay_bit_o = bit_i;
  assign busy_o    = (state_q != CAP_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= CAP_IDLE;
      sreg_q     <= '0;
      acnt_q     <= '0;
      pcnt_q     <= '0;
      addr_vld_o <= 1'b0;
      addr_o     <= '0;
      err_o      <= 1'b0;
    end else begin
      addr_vld_o <= 1'b0;
      err_o      <= sop_i & bit_vld_i & (state_q != CAP_IDLE);
      if (clean_i) begin
        state_q <= CAP_IDLE;
      end else begin
        unique case (state_q)
          CAP_IDLE: if (sop_i && bit_vld_i) begin
            sreg_q  <= {sreg_q[LA-2:0], bit_i};
            acnt_q  <= ACW'(1);
            state_q <= CAP_ADDR;
          end
          CAP_ADDR: if (take) begin
            sreg_q <= {sreg_q[LA-2:0], bit_i};
            if (acnt_q == ACW'(LA - 1)) begin
              addr_o     <= {sreg_q[LA-2:0], bit_i};
              addr_vld_o <= 1'b1;
              pcnt_q     <= '0;
              state_q    <= CAP_PAY;
            end else begin
              acnt_q <= acnt_q + ACW'(1);
            end
          end
          CAP_PAY: if (take) begin
            if (pcnt_q == PCW'(PAY_LEN - 1)) state_q <= CAP_HOLD;
            else                             pcnt_q  <= pcnt_q + PCW'(1);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xic_token_gen.sv
module xic_token_gen #(
  parameter int N_COLS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [$clog2(N_COLS)-1:0] addr_i,
  input  logic                      consume_i,
  output logic                      token_vld_o,
  output logic [N_COLS-1:0]         token_o
);
  localparam int LA = $clog2(N_COLS);
  localparam logic [N_COLS-1:0] COL0 = N_COLS'(1);

  logic [LA-1:0]     acnt_q;   // wraps after N-A steps
  logic [LA-1:0]     ncnt_q;   // bounds the run to N steps
  logic              run_q;
  logic              placed_q;
  logic [N_COLS-1:0] tok_q;

  assign token_o = placed_q ? tok_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acnt_q      <= '0;
      ncnt_q      <= '0;
      run_q       <= 1'b0;
      placed_q    <= 1'b0;
      tok_q       <= '0;
      token_vld_o <= 1'b0;
    end else if (load_i) begin
      acnt_q      <= addr_i;
      ncnt_q      <= '0;
      run_q       <= 1'b1;
      placed_q    <= 1'b0;
      tok_q       <= '0;
      token_vld_o <= 1'b0;
    end else begin
      token_vld_o <= 1'b0;
      if (consume_i) placed_q <= 1'b0;
      if (run_q) begin
        acnt_q <= acnt_q + LA'(1);
        if (acnt_q == '1)  tok_q <= COL0;
        else if (|tok_q)   tok_q <= tok_q << 1;
        if (ncnt_q == LA'(N_COLS - 1)) begin
          run_q       <= 1'b0;
          placed_q    <= 1'b1;
          token_vld_o <= 1'b1;
        end else begin
          ncnt_q <= ncnt_q + LA'(1);
        end
      end
    end
  end
endmodule

// File: rtl/xic_pay_dly.sv
module xic_pay_dly #(
  parameter int DEPTH = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic bit_i,
  output logic vld_o,
  output logic bit_o
);
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] dat_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic v_in, d_in;
    if (s == 0) begin : g_head
      assign v_in = vld_i;
      assign d_in = bit_i;
    end else begin : g_body
      assign v_in = vld_q[s-1];
      assign d_in = dat_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        dat_q[s] <= 1'b0;
      end else begin
        vld_q[s] <= v_in;
        dat_q[s] <= d_in & v_in;
      end
    end
  end

  assign vld_o = vld_q[DEPTH-1];
  assign bit_o = dat_q[DEPTH-1];
endmodule

// File: rtl/xic_xpt_col.sv
module xic_xpt_col #(
  parameter int N_COLS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clean_i,
  input  logic              select_i,
  input  logic [N_COLS-1:0] token_i,
  output logic [N_COLS-1:0] xpt_o
);
  logic set_en;
  assign set_en = select_i & (|token_i);

  for (genvar c = 0; c < N_COLS; c++) begin : g_node
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      xpt_o[c] <= 1'b0;
      else if (set_en)  xpt_o[c] <= token_i[c];
      else if (clean_i) xpt_o[c] <= 1'b0;
    end
  end
endmodule

// File: rtl/xbar_in_ctrl.sv
module xbar_in_ctrl #(
  parameter int N_COLS  = 8,
  parameter int PAY_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sop_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              clean_i,
  input  logic              select_i,
  output logic              pay_vld_o,
  output logic              pay_o,
  output logic              token_vld_o,
  output logic [N_COLS-1:0] token_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [N_COLS-1:0] xpt_o
);
  localparam int LA      = $clog2(N_COLS);
  localparam int PAY_DLY = 2 + PAY_LEN - LA;

  logic          addr_vld;
  logic [LA-1:0] addr;
  logic          pin_vld, pin_bit;

  xic_addr_capture #(.N_COLS(N_COLS), .PAY_LEN(PAY_LEN)) u_cap (
    .clk_i, .rst_ni, .sop_i, .bit_vld_i, .bit_i, .clean_i,
    .addr_vld_o(addr_vld), .addr_o(addr),
    .pay_vld_o(pin_vld), .pay_bit_o(pin_bit),
    .busy_o, .err_o
  );

  xic_token_gen #(.N_COLS(N_COLS)) u_tok (
    .clk_i, .rst_ni, .load_i(addr_vld), .addr_i(addr),
    .consume_i(select_i), .token_vld_o, .token_o
  );

  xic_pay_dly #(.DEPTH(PAY_DLY)) u_dly (
    .clk_i, .rst_ni, .vld_i(pin_vld), .bit_i(pin_bit),
    .vld_o(pay_vld_o), .bit_o(pay_o)
  );

  xic_xpt_col #(.N_COLS(N_COLS)) u_xpt (
    .clk_i, .rst_ni, .clean_i, .select_i, .token_i(token_o), .xpt_o
  );
endmodule

// File: rtl/xic_chk.sv
module xic_chk #(
  parameter int N_COLS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sop_i,
  input logic              bit_vld_i,
  input logic              clean_i,
  input logic              select_i,
  input logic              addr_vld,
  input logic              token_vld_o,
  input logic [N_COLS-1:0] token_o,
  input logic              busy_o,
  input logic              err_o,
  input logic [N_COLS-1:0] xpt_o
);
  localparam int LW = $clog2(N_COLS) + 2;
  logic [LW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lat_q <= '1;
    else if (addr_vld)    lat_q <= '0;
    else if (lat_q != '1) lat_q <= lat_q + LW'(1);
  end

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_vld_o |-> lat_q == LW'(N_COLS));
  // R3
  token_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_vld_o |-> $countones(token_o) == 1);
  // R6
  busy_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_i && bit_vld_i && busy_o) |=> err_o);
  // R7
  clean_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean_i |=> !busy_o);
  // R8
  clean_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clean_i && !select_i) |=> xpt_o == '0);
  // R9
  select_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (select_i && token_o != '0) |=> (xpt_o == $past(token_o)) && (token_o == '0));
  // R9
  xpt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(xpt_o));
endmodule

bind xbar_in_ctrl xic_chk #(.N_COLS(N_COLS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sop_i(sop_i), .bit_vld_i(bit_vld_i),
  .clean_i(clean_i), .select_i(select_i), .addr_vld(addr_vld),
  .token_vld_o(token_vld_o), .token_o(token_o), .busy_o(busy_o),
  .err_o(err_o), .xpt_o(xpt_o)
);

// File: tb/sim_xbar_in_ctrl.sv
module sim_xbar_in_ctrl;
  localparam int N  = 8;
  localparam int L  = 16;
  localparam int LA = 3;
  localparam int D  = 2 + L - LA;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sop_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, clean_i = 1'b0, select_i = 1'b0;
  logic pay_vld_o, pay_o, token_vld_o, busy_o, err_o;
  logic [N-1:0] token_o, xpt_o;

  always #2 clk_i = ~clk_i;

  xbar_in_ctrl #(.N_COLS(N), .PAY_LEN(L)) u0 (.*);

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  int pay_bit_q[$], pay_cyc_q[$], tok_col_q[$], tok_cyc_q[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h cyc=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) if (rst_ni) begin
    if (pay_vld_o) begin
      if (pay_bit_q.size() == 0) chk(0, "R4/R6/R11 unexpected payload", 1, 0);
      else begin
        int eb, ec;
        eb = pay_bit_q.pop_front();
        ec = pay_cyc_q.pop_front();
        chk(pay_o == eb[0], "R4 payload bit", int'(pay_o), eb);
        chk(cyc == ec, "R4 payload delay", cyc, ec);
      end
    end
    if (token_vld_o) begin
      if (tok_col_q.size() == 0) chk(0, "R11 unexpected token", 1, 0);
      else begin
        int ea, ec;
        ea = tok_col_q.pop_front();
        ec = tok_cyc_q.pop_front();
        chk(token_o == N'(1) << ea, "R1 token column", int'(token_o), 1 << ea);
        chk(cyc == ec, "R2 token latency", cyc, ec);
      end
    end
  end

  task automatic send_pkt(input int addr, input logic [L-1:0] pay, input int gap_at);
    for (int i = 0; i < LA + L; i++) begin
      @(negedge clk_i);
      if (i == gap_at) begin
        sop_i = 1'b0; bit_vld_i = 1'b0;  // R5 gap
        @(negedge clk_i);
      end
      sop_i     = (i == 0);
      bit_vld_i = 1'b1;
      bit_i     = (i < LA) ? addr[LA-1-i] : pay[L-1-(i-LA)];
      if (i == LA - 1) begin tok_col_q.push_back(addr); tok_cyc_q.push_back(cyc + N + 2); end
      if (i >= LA)     begin pay_bit_q.push_back(int'(bit_i)); pay_cyc_q.push_back(cyc + D); end
    end
    @(negedge clk_i);
    sop_i = 1'b0; bit_vld_i = 1'b0;
  endtask

  task automatic pulse(input bit cl, input bit sel);
    @(negedge clk_i); clean_i = cl; select_i = sel;
    @(negedge clk_i); clean_i = 1'b0; select_i = 1'b0;
  endtask

  task automatic settle();
    repeat (N + D + 4) @(negedge clk_i);
  endtask

  task automatic reprogram(input int addr, input string tag);
    chk(token_o == N'(1) << addr, {"R3 token held ", tag}, int'(token_o), 1 << addr);
    pulse(1, 0);
    chk(busy_o == 0, {"R7 idle after clean ", tag}, int'(busy_o), 0);
    chk(xpt_o == 0, {"R8 open after clean ", tag}, int'(xpt_o), 0);
    pulse(0, 1);
    chk(xpt_o == N'(1) << addr, {"R9 close at token ", tag}, int'(xpt_o), 1 << addr);
    chk(token_o == 0, {"R9 token consumed ", tag}, int'(token_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk({busy_o, err_o, pay_vld_o, token_vld_o} == 0, "R10 reset flags",
        int'({busy_o, err_o, pay_vld_o, token_vld_o}), 0);
    chk(token_o == 0 && xpt_o == 0, "R10 reset vectors", int'({token_o, xpt_o}), 0);
    rst_ni = 1'b1;

    // R11: stray bits while idle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i); bit_vld_i = 1'b1; bit_i = i[0];
    end
    @(negedge clk_i); bit_vld_i = 1'b0;
    chk(busy_o == 0, "R11 no start without sop", int'(busy_o), 0);

    send_pkt(5, 16'hA5C3, -1);
    settle();
    chk(busy_o == 1, "R6 busy until clean", int'(busy_o), 1);
    // R6: start while busy
    @(negedge clk_i); sop_i = 1'b1; bit_vld_i = 1'b1; bit_i = 1'b1;
    @(negedge clk_i); sop_i = 1'b0; bit_vld_i = 1'b0;
    chk(err_o == 1, "R6 err pulse", int'(err_o), 1);
    @(negedge clk_i);
    chk(err_o == 0, "R6 err one cycle", int'(err_o), 0);
    reprogram(5, "col5");
    pulse(0, 1);  // R9 select with no token
    chk(xpt_o == N'(1) << 5, "R9 select without token keeps xpt", int'(xpt_o), 1 << 5);

    send_pkt(0, 16'h0F1E, 1);        // R5 gap in address
    settle();
    reprogram(0, "col0");

    send_pkt(N - 1, 16'h3C96, LA + 4); // R5 gap in payload
    settle();
    reprogram(N - 1, "colmax");

    // back-to-back: clean right after the last bit, then next packet
    send_pkt(2, 16'hBEEF, -1);
    pulse(1, 0);
    send_pkt(6, 16'h1234, -1);
    settle();
    reprogram(6, "b2b");

    repeat (N + D + 4) @(negedge clk_i);
    chk(pay_bit_q.size() == 0, "R4 all payload seen", pay_bit_q.size(), 0);
    chk(tok_col_q.size() == 0, "R2 all tokens seen", tok_col_q.size(), 0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    summary();
  end
endmodule